// File: doc/BRIEF.md
# Signed/Unsigned Byte Multiply Unit

This unit multiplies two byte operands and returns a 16-bit product as a high byte and a low byte. A mode pin selects an unsigned or a two's complement signed interpretation of the operands. Unsigned products come straight from an unsigned multiplier array and are ready one cycle after the request is taken. Signed products reuse the same unsigned array. A fixed correction sequence then runs over the high byte. It first checks the sign bit of the second operand and, if that bit is set, subtracts the first operand. It then checks the sign bit of the first operand and, if that bit is set, subtracts the second operand. Empty pad cycles follow, so every signed request has the same latency.

Requests enter on a valid/ready handshake. A request is taken on a rising edge where `in_valid` and `in_ready` are both high, and the operands and mode are captured on that edge. While a signed sequence runs, `in_ready` stays low and anything offered on the request pins is ignored. The requester must hold its request until `in_ready` is high. The result side has no back-pressure. `out_valid` is a one-cycle strobe that marks the cycle in which the product registers first hold the final value. The product then stays in the registers until the next request is taken. The unit drives no condition or status flags.

Top module: `byte_mul_unit`

## Requirements
- R1: When a request with `in_signed`=0 is taken, `out_valid` is 1 in the next cycle and {`prod_hi`,`prod_lo`} equals the unsigned product of `in_a` and `in_b`.
- R2: When a request with `in_signed`=1 is taken, {`prod_hi`,`prod_lo`} at `out_valid` equals the two's complement product of the operands, reduced modulo 65536.
- R3: For a signed request, `out_valid` rises after the sixth rising edge, counting the accepting edge as the first, for all sign-bit combinations. `in_ready` and `out_valid` are both 0 in the five cycles between.
- R4: From the cycle after a signed request is taken until its `out_valid` cycle, `prod_lo` equals the low byte of the unsigned product and does not change.
- R5: In the cycle after a signed request is taken, `prod_hi` is the unsigned high byte. One edge later, if bit 7 of the second operand is set, `in_a` has been subtracted from it modulo 256. On the following edge, if bit 7 of the first operand is set, `in_b` has been subtracted modulo 256. After that, `prod_hi` does not change.
- R6: `out_valid` is high for exactly one cycle per result. Back-to-back unsigned requests give one strobe in each cycle.
- R7: Changes on `in_valid`, `in_a`, `in_b` or `in_signed` while `in_ready` is 0 have no effect on the result or its timing.
- R8: After reset, `out_valid` is 0, `in_ready` is 1, and both product bytes are 0.
- R9: While the unit is idle and no request is taken, both product bytes hold their values and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit can take a request |
| in_a | input | 8 | First operand |
| in_b | input | 8 | Second operand |
| in_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| out_valid | output | 1 | One-cycle strobe: product is final |
| prod_hi | output | 8 | Product bits 15..8 |
| prod_lo | output | 8 | Product bits 7..0 |

## Verification
Every unsigned operand pair is sent back to back. This catches an array bug, and a strobe that drops or doubles under continuous traffic. Signed requests use random operands plus the four sign-bit combinations and the extreme values 0x80 and 0xFF. The bench checks the high byte after each correction edge. A design that swapped the two tests, kept the borrow, or applied a subtraction unconditionally would show a wrong intermediate or final high byte. During each signed sequence the bench keeps offering junk operands. It also checks that the strobe falls on the sixth edge whether zero, one or two subtractions apply. A design that skipped padding, accepted during busy, or touched the low byte would fail these checks.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int unsigned OPW_DEF = 8;
  localparam int unsigned SLAT_DEF = 6;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIXB  = 2'd1,
    PH_FIXA  = 2'd2,
    PH_PAD   = 2'd3
  } phase_t;
endpackage

// File: rtl/umul_array.sv
module umul_array #(
  parameter int unsigned OPW = mul_pkg::OPW_DEF
) (
  input  logic [OPW-1:0]   mul_x,
  input  logic [OPW-1:0]   mul_y,
  output logic [2*OPW-1:0] mul_p
);
  localparam int unsigned PW = 2 * OPW;

  logic [PW-1:0] row  [OPW];
  logic [PW-1:0] accu [OPW+1];

  assign accu[0] = '0;

  // one shifted partial product per multiplier bit, summed as a chain
  for (genvar r = 0; r < OPW; r++) begin : g_row
    assign row[r]    = mul_y[r] ? ({{OPW{1'b0}}, mul_x} << r) : '0;
    assign accu[r+1] = accu[r] + row[r];
  end

  assign mul_p = accu[OPW];
endmodule

// File: rtl/hi_fixup.sv
module hi_fixup #(
  parameter int unsigned OPW = mul_pkg::OPW_DEF
) (
  input  logic [OPW-1:0] fx_hi,
  input  logic [OPW-1:0] fx_sub,
  input  logic           fx_en,
  output logic [OPW-1:0] fx_out
);
  // modulo 2^OPW: borrow out of the top bit is dropped
  always_comb begin
    if (fx_en) fx_out = fx_hi - fx_sub;
    else       fx_out = fx_hi;
  end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int unsigned SLAT = mul_pkg::SLAT_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_signed,
  output logic busy,
  output logic step_b,
  output logic step_a,
  output logic finish
);
  import mul_pkg::*;

  localparam int unsigned CW = (SLAT < 4) ? 2 : $clog2(SLAT);
  localparam logic [CW-1:0] LAST = CW'(SLAT - 1);

  phase_t        ph_q;
  logic [CW-1:0] cnt_q;

  assign busy   = (ph_q != PH_IDLE);
  assign step_b = (ph_q == PH_FIXB);
  assign step_a = (ph_q == PH_FIXA);
  assign finish = busy && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (go_signed) begin
            ph_q  <= PH_FIXB;
            cnt_q <= CW'(1);
          end
        end
        PH_FIXB: begin
          ph_q  <= PH_FIXA;
          cnt_q <= cnt_q + 1'b1;
        end
        PH_FIXA, PH_PAD: begin
          if (finish) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else begin
            ph_q  <= PH_PAD;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/byte_mul_unit.sv
module byte_mul_unit #(
  parameter int unsigned OPW  = mul_pkg::OPW_DEF,
  parameter int unsigned SLAT = mul_pkg::SLAT_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_a,
  input  logic [OPW-1:0] in_b,
  input  logic           in_signed,
  output logic           out_valid,
  output logic [OPW-1:0] prod_hi,
  output logic [OPW-1:0] prod_lo
);
  localparam int unsigned PW = 2 * OPW;

  logic           take;
  logic           busy, step_b, step_a, finish;
  logic [OPW-1:0] opa_q, opb_q;
  logic [PW-1:0]  raw_p;
  logic [OPW-1:0] sub_val, new_hi;
  logic           sub_en;
  logic           done_q;
  logic [OPW-1:0] hi_q, lo_q;

  assign in_ready = !busy;
  assign take     = in_valid && in_ready;

  umul_array #(.OPW(OPW)) u_array (
    .mul_x (in_a),
    .mul_y (in_b),
    .mul_p (raw_p)
  );

  mul_ctrl #(.SLAT(SLAT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_signed (take && in_signed),
    .busy      (busy),
    .step_b    (step_b),
    .step_a    (step_a),
    .finish    (finish)
  );

  // first step tests the second operand's sign and removes the first operand;
  // second step does the reverse
  assign sub_val = step_b ? opa_q : opb_q;
  assign sub_en  = step_b ? opb_q[OPW-1] : (step_a && opa_q[OPW-1]);

  hi_fixup #(.OPW(OPW)) u_fix (
    .fx_hi  (hi_q),
    .fx_sub (sub_val),
    .fx_en  (sub_en),
    .fx_out (new_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q  <= '0;
      opb_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      opa_q  <= in_a;
      opb_q  <= in_b;
      hi_q   <= raw_p[PW-1:OPW];
      lo_q   <= raw_p[OPW-1:0];
      done_q <= !in_signed;
    end else begin
      if (step_b || step_a) hi_q <= new_hi;
      done_q <= finish;
    end
  end

  assign out_valid = done_q;
  assign prod_hi   = hi_q;
  assign prod_lo   = lo_q;
endmodule

// File: rtl/byte_mul_unit_chk.sv
module byte_mul_unit_chk #(
  parameter int unsigned OPW  = 8,
  parameter int unsigned SLAT = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           in_signed,
  input logic           out_valid,
  input logic [OPW-1:0] prod_hi,
  input logic [OPW-1:0] prod_lo
);
  localparam int unsigned CW = $clog2(SLAT + 1);
  localparam logic [CW-1:0] LATV = CW'(SLAT);

  logic          acc;
  logic [CW-1:0] since_q;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                 since_q <= '0;
    else if (acc && in_signed)  since_q <= CW'(1);
    else if (since_q == LATV)   since_q <= '0;
    else if (since_q != '0)     since_q <= since_q + 1'b1;
  end

  // R1
  uns_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_signed) |=> out_valid);

  // R3
  sgn_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q != '0 && since_q < LATV) |-> (!out_valid && !in_ready));

  // R3
  sgn_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q == LATV) |-> (out_valid && in_ready));

  // R4
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(prod_lo));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(prod_hi) && $stable(prod_lo) && !out_valid));
endmodule

bind byte_mul_unit byte_mul_unit_chk #(.OPW(OPW), .SLAT(SLAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_signed (in_signed),
  .out_valid (out_valid),
  .prod_hi   (prod_hi),
  .prod_lo   (prod_lo)
);

// File: tb/byte_mul_unit_bench.sv
`timescale 1ns/1ps
module byte_mul_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic       in_signed = 1'b0;
  logic       out_valid;
  logic [7:0] prod_hi, prod_lo;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  byte_mul_unit u_byte_mul_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_signed(in_signed),
    .out_valid(out_valid), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  function automatic int umul(int a, int b);
    return (a * b) & 16'hFFFF;
  endfunction

  function automatic int smul(int a, int b);
    int sa, sb;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    return (sa * sb) & 16'hFFFF;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // one signed request with junk offered on the inputs while busy
  task automatic run_signed(int a, int b);
    int u, s, h1, h2, h3;
    u  = umul(a, b);
    s  = smul(a, b);
    h1 = u >> 8;
    h2 = (b > 127) ? ((h1 - a) & 255) : h1;
    h3 = (a > 127) ? ((h2 - b) & 255) : h2;
    @(negedge clk);
    in_a = 8'(a); in_b = 8'(b); in_signed = 1'b1; in_valid = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      // R7: junk operands and mode while not ready
      in_a = 8'($urandom); in_b = 8'($urandom); in_signed = 1'($urandom);
      in_valid = (k < 5);
      if (k < 6) begin
        check(!out_valid && !in_ready, "R3 busy strobe/ready", {out_valid, in_ready}, 0);
        check(prod_lo == 8'(u), "R4 low byte", prod_lo, u & 255);
      end
      if (k == 1) check(prod_hi == 8'(h1), "R5 unsigned high byte", prod_hi, h1);
      if (k == 2) check(prod_hi == 8'(h2), "R5 after b-sign step", prod_hi, h2);
      if (k >= 3 && k < 6) check(prod_hi == 8'(h3), "R5 after a-sign step", prod_hi, h3);
      if (k == 6) begin
        check(out_valid && in_ready, "R3 strobe on sixth edge", {out_valid, in_ready}, 3);
        check({prod_hi, prod_lo} == 16'(s), "R2 R7 signed product", {prod_hi, prod_lo}, s);
      end
    end
    @(negedge clk);
    check(!out_valid, "R6 single strobe", out_valid, 0);
    check({prod_hi, prod_lo} == 16'(s), "R9 product held", {prod_hi, prod_lo}, s);
  endtask

  initial begin
    #(5.0 * 190000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int prev;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8
    check(!out_valid && in_ready && prod_hi == 0 && prod_lo == 0, "R8 reset state",
          {out_valid, in_ready, prod_hi, prod_lo}, 18'h10000);

    // R1, R6: every unsigned pair, back to back
    prev = 0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(out_valid, "R6 strobe per result", out_valid, 1);
        check({prod_hi, prod_lo} == 16'(prev), "R1 unsigned product", {prod_hi, prod_lo}, prev);
      end
      in_a = 8'(i >> 8); in_b = 8'(i); in_signed = 1'b0; in_valid = 1'b1;
      prev = umul(i >> 8, i & 255);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {prod_hi, prod_lo} == 16'(prev), "R1 last unsigned", {prod_hi, prod_lo}, prev);
    @(negedge clk);
    check(!out_valid && {prod_hi, prod_lo} == 16'(prev), "R9 idle hold", {prod_hi, prod_lo}, prev);

    // directed signed corners: all sign combinations and extremes
    run_signed(8'h80, 8'h80);
    run_signed(8'h80, 8'hFF);
    run_signed(8'hFF, 8'hFF);
    run_signed(8'h7F, 8'h80);
    run_signed(8'h80, 8'h7F);
    run_signed(8'h00, 8'h80);
    run_signed(8'h7F, 8'h7F);
    run_signed(8'h01, 8'hFF);

    // random signed
    for (int j = 0; j < 2000; j++) run_signed($urandom & 255, $urandom & 255);

    // unsigned directly after a signed result
    run_signed(8'hC3, 8'h5A);
    @(negedge clk);
    in_a = 8'hFF; in_b = 8'hFF; in_signed = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {prod_hi, prod_lo} == 16'hFE01, "R1 after signed", {prod_hi, prod_lo}, 16'hFE01);

    summary();
  end
endmodule